// File: doc/BRIEF.md
# B2 Burst Signal-Fail Detector

This block watches the line parity error counts that a receive overhead processor reports once per STS-3 frame. It raises a Signal Fail alarm when too many errors pile up within a short run of recent frames. It drops the alarm again only when a second run of recent frames shows the error total has fallen under the same limit. A single 16-bit limit serves both decisions. Because the two decisions look at windows that can differ in length and use opposite comparisons, the alarm behaves with hysteresis rather than tracking one running count.

Each frame strobe carries an error count from 0 to 24. Two ring buffers of up to 16 entries keep the counts for the arm window and the release window, and each buffer keeps a running sum beside it. Software programs the limit and both window lengths through a byte-wide write port. Any write empties both windows, so a window takes part in a decision only after it has refilled with fresh frames. The decision is registered one cycle after the frame update. Single-cycle pulses mark each change of state.

Top module: `b2_sf_burst_det`

## Requirements
- R1: After reset the alarm and both pulses are low, the limit is 0xFFFF and both window lengths are 16 frames. With the limit at 0xFFFF the alarm is never raised, because the largest possible window sum is 384.
- R2: A write with wr_en high stores wr_data into a register chosen by wr_addr. Address 0 holds limit bits 15:8 and address 1 holds limit bits 7:0. Address 2 holds the arm window length minus one in bits 3:0, and address 3 holds the release window length minus one in bits 3:0. Bits 7:4 at addresses 2 and 3 are ignored.
- R3: While the alarm is low and the arm window holds its full N frames, a frame whose update brings the sum of the last N counts to or above the limit raises the alarm. The strobe is sampled at clock edge k and sf_active rises at edge k+1. With a limit of 0, the alarm rises as soon as the arm window is full.
- R4: While the alarm is high and the release window holds its full M frames, the alarm falls when the sum of the last M counts is strictly below the limit. It stays high when that sum equals or exceeds the limit. The timing is the same as in R3.
- R5: Each window slides. Once a window is full, every new frame drops the oldest count in that window.
- R6: Any register write empties both windows but leaves the alarm state unchanged. No decision uses a window until it has received its full length of new frames.
- R7: A frame strobe that arrives in the same cycle as a register write is discarded and enters neither window.
- R8: sf_set_pulse is high for exactly the one cycle in which sf_active has just risen. sf_clr_pulse is high for exactly the one cycle in which sf_active has just fallen. The two pulses never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe, one per received frame |
| b2_err | input | 5 | Parity error count of this frame, 0 to 24 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| sf_active | output | 1 | Signal Fail alarm state |
| sf_set_pulse | output | 1 | One-cycle pulse when the alarm rises |
| sf_clr_pulse | output | 1 | One-cycle pulse when the alarm falls |

## Verification
A frame strobe is captured into the window sums at the edge where it is sampled. The alarm and its pulses change at the next edge, so they are due two edges after the strobe is driven. Each frame task drives its strobe at a falling edge and then waits two more falling edges before the scenario reads sf_active and the pulses, which means it samples exactly where the new value has settled. Register writes take one edge. Pulse width is confirmed by reading again one falling edge later, when the pulse must already be low.

// File: rtl/b2_sf_pkg.sv
// Package: shared sizes for the burst Signal-Fail detector.
// Assumes at most 24 errors per frame and at most 16 frames per window.
package b2_sf_pkg;
    localparam int ERR_W   = 5;
    localparam int SUM_W   = 16;
    localparam int WIN_MAX = 16;
    localparam int LEN_W   = $clog2(WIN_MAX);

    typedef enum logic [1:0] {
        REG_THR_HI = 2'd0,
        REG_THR_LO = 2'd1,
        REG_ARM    = 2'd2,
        REG_REL    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/b2_sf_cfg.sv
// Configuration registers: limit, arm length and release length.
// Assumes a write happens in a single cycle. Any write flushes both windows.
module b2_sf_cfg #(
    parameter int SUM_W = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    output logic [SUM_W-1:0] thr,
    output logic [LEN_W-1:0] arm_len_m1,
    output logic [LEN_W-1:0] rel_len_m1,
    output logic             flush
);
    import b2_sf_pkg::*;

    logic [15:0] thr_q;

    // Register file update; the upper data bits of the length fields are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q      <= 16'hFFFF;
            arm_len_m1 <= '1;
            rel_len_m1 <= '1;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_THR_HI: thr_q[15:8] <= wr_data;
                REG_THR_LO: thr_q[7:0]  <= wr_data;
                REG_ARM:    arm_len_m1  <= wr_data[LEN_W-1:0];
                REG_REL:    rel_len_m1  <= wr_data[LEN_W-1:0];
                default:    ;
            endcase
        end
    end

    // The limit is always 16 bits; widen or trim it to the sum width.
    assign thr   = SUM_W'(thr_q);
    assign flush = wr_en;
endmodule

// File: rtl/b2_sf_window.sv
// Sliding window sum: a ring of per-frame counts plus a running total.
// Assumes the length changes only together with a flush. Once the ring
// is full, each push replaces the oldest entry. The total saturates.
module b2_sf_window #(
    parameter int DEPTH = 16,
    parameter int ERR_W = 5,
    parameter int SUM_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  logic [ERR_W-1:0]         din,
    input  logic [$clog2(DEPTH)-1:0] len_m1,
    output logic [SUM_W-1:0]         sum,
    output logic                     full
);
    localparam int PW = $clog2(DEPTH);

    logic [ERR_W-1:0] ring [DEPTH];
    logic [PW-1:0]    ptr;
    logic [PW:0]      fill;
    logic [SUM_W:0]   nxt;

    assign full = (fill == ({1'b0, len_m1} + 1'b1));

    // Next total: add the new count and, when full, drop the oldest one.
    always_comb begin
        nxt = {1'b0, sum} + (SUM_W+1)'(din);
        if (full) nxt = nxt - (SUM_W+1)'(ring[ptr]);
    end

    // Ring storage; holds data only, so it needs no reset.
    always_ff @(posedge clk) begin
        if (push) ring[ptr] <= din;
    end

    // Pointer, fill level and running total.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr  <= '0;
            fill <= '0;
            sum  <= '0;
        end else if (push) begin
            ptr <= (ptr == len_m1) ? '0 : ptr + 1'b1;
            if (!full) fill <= fill + 1'b1;
            sum <= nxt[SUM_W] ? '1 : nxt[SUM_W-1:0];
        end
    end

    // The fill level never passes the programmed length.
    p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= ({1'b0, len_m1} + 1'b1));
    // A flush leaves the window empty.
    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (sum == '0 && !full));
endmodule

// File: rtl/b2_sf_decide.sv
// Alarm state machine. It evaluates one cycle after a frame enters the
// windows. It raises the alarm on the arm window and drops it on the release window.
module b2_sf_decide #(
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic [SUM_W-1:0] thr,
    input  logic [SUM_W-1:0] arm_sum,
    input  logic             arm_full,
    input  logic [SUM_W-1:0] rel_sum,
    input  logic             rel_full,
    output logic             sf,
    output logic             set_p,
    output logic             clr_p
);
    logic go_set, go_clr;

    // Decide this cycle's transition from the settled window sums.
    always_comb begin
        go_set = eval && !sf && arm_full && (arm_sum >= thr);
        go_clr = eval &&  sf && rel_full && (rel_sum <  thr);
    end

    // Alarm state and its one-cycle change pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf    <= 1'b0;
            set_p <= 1'b0;
            clr_p <= 1'b0;
        end else begin
            set_p <= go_set;
            clr_p <= go_clr;
            if (go_set)      sf <= 1'b1;
            else if (go_clr) sf <= 1'b0;
        end
    end

    // Outside an evaluation cycle the alarm holds.
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> $stable(sf));
    // A release sum at or above the limit keeps the alarm high.
    p_rel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sf && rel_sum >= thr) |=> sf);
    // The set pulse marks a rise of the alarm.
    p_set_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_p |-> (sf && !$past(sf)));
    // The clear pulse marks a fall of the alarm.
    p_clr_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_p |-> (!sf && $past(sf)));
    // The two pulses never occur together.
    p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_p && clr_p));
endmodule

// File: rtl/b2_sf_burst_det.sv
// Top of the burst Signal-Fail detector. It connects the configuration
// registers, the arm and release windows and the decision stage.
// Assumes frame_stb lasts one cycle per frame and b2_err <= 24.
module b2_sf_burst_det #(
    parameter int ERR_W   = b2_sf_pkg::ERR_W,
    parameter int SUM_W   = b2_sf_pkg::SUM_W,
    parameter int WIN_MAX = b2_sf_pkg::WIN_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [ERR_W-1:0] b2_err,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    output logic             sf_active,
    output logic             sf_set_pulse,
    output logic             sf_clr_pulse
);
    localparam int LEN_W = $clog2(WIN_MAX);
    localparam int NWIN  = 2;

    logic [SUM_W-1:0] thr;
    logic [LEN_W-1:0] len_m1 [NWIN];
    logic [SUM_W-1:0] wsum   [NWIN];
    logic             wfull  [NWIN];
    logic             flush, push, eval;

    b2_sf_cfg #(.SUM_W(SUM_W), .LEN_W(LEN_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .thr(thr), .arm_len_m1(len_m1[0]),
        .rel_len_m1(len_m1[1]), .flush(flush)
    );

    // A frame that coincides with a write is discarded.
    assign push = frame_stb && !flush;

    // One window per decision: index 0 arms, index 1 releases.
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        b2_sf_window #(.DEPTH(WIN_MAX), .ERR_W(ERR_W), .SUM_W(SUM_W)) win_i (
            .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
            .din(b2_err), .len_m1(len_m1[g]), .sum(wsum[g]), .full(wfull[g])
        );
    end

    // Evaluate one cycle after an accepted frame, once the sums have settled.
    always_ff @(posedge clk) begin
        if (!rst_n) eval <= 1'b0;
        else        eval <= push;
    end

    b2_sf_decide #(.SUM_W(SUM_W)) dec_i (
        .clk(clk), .rst_n(rst_n), .eval(eval), .thr(thr),
        .arm_sum(wsum[0]), .arm_full(wfull[0]),
        .rel_sum(wsum[1]), .rel_full(wfull[1]),
        .sf(sf_active), .set_p(sf_set_pulse), .clr_p(sf_clr_pulse)
    );

    // Input range the windows are sized for.
    p_err_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> (b2_err <= 5'd24));
endmodule

// File: tb/b2_sf_burst_det_tb_top.sv
// Directed bench for the burst Signal-Fail detector.
module b2_sf_burst_det_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic [4:0] b2_err = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sf_active, sf_set_pulse, sf_clr_pulse;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    b2_sf_burst_det dut_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .b2_err(b2_err),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sf_active(sf_active), .sf_set_pulse(sf_set_pulse),
        .sf_clr_pulse(sf_clr_pulse)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr_reg(logic [1:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Drive one frame. The task returns after the edge at which the decision lands.
    task automatic frame(int c);
        @(negedge clk); frame_stb = 1'b1; b2_err = 5'(c);
        @(negedge clk); frame_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_defaults();
        do_reset();
        chk("R1 sf after reset", sf_active, 0);
        chk("R1 set pulse after reset", sf_set_pulse, 0);
        chk("R1 clr pulse after reset", sf_clr_pulse, 0);
        for (int i = 0; i < 16; i++) frame(24);
        chk("R1 limit 0xFFFF never arms", sf_active, 0);
        wr_reg(2'd0, 8'h00);                    // limit becomes 0x00FF
        for (int i = 0; i < 15; i++) frame(20);
        chk("R1 default length 16 not yet full", sf_active, 0);
        frame(20);
        chk("R2 R1 arms at 16 frames over 0x00FF", sf_active, 1);
    endtask

    task automatic t_arm_slide();
        do_reset();
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'd10);
        wr_reg(2'd2, 8'hF3);                    // upper bits ignored: length 4
        wr_reg(2'd3, 8'h03);
        frame(12); frame(0); frame(0);
        chk("R6 partial window no decision", sf_active, 0);
        wr_reg(2'd1, 8'd10);                    // flush
        chk("R6 write keeps sf low", sf_active, 0);
        frame(5); frame(0); frame(0); frame(0);
        chk("R3 full sum 5 below 10", sf_active, 0);
        frame(5);
        chk("R5 oldest dropped, sum 5", sf_active, 0);
        frame(6);
        chk("R3 sum 11 arms", sf_active, 1);
        chk("R8 set pulse", sf_set_pulse, 1);
        @(negedge clk);
        chk("R8 set pulse one cycle", sf_set_pulse, 0);
    endtask

    task automatic t_release();
        frame(4);
        chk("R4 sum 15 holds", sf_active, 1);
        frame(0);
        chk("R4 sum 15 holds again", sf_active, 1);
        frame(0);
        chk("R4 sum equal to limit holds", sf_active, 1);
        frame(0);
        chk("R4 sum 4 releases", sf_active, 0);
        chk("R8 clr pulse", sf_clr_pulse, 1);
        chk("R8 no set pulse on release", sf_set_pulse, 0);
        @(negedge clk);
        chk("R8 clr pulse one cycle", sf_clr_pulse, 0);
    endtask

    task automatic t_flush_hold();
        frame(10);
        chk("R3 sum equal to limit arms", sf_active, 1);
        wr_reg(2'd3, 8'h01);                    // release length 2, flush
        chk("R6 write keeps sf high", sf_active, 1);
        frame(0);
        chk("R6 release window refilling", sf_active, 1);
        frame(0);
        chk("R4 length 2 releases", sf_active, 0);
    endtask

    task automatic t_coincident();
        @(negedge clk);
        frame_stb = 1'b1; b2_err = 5'd20;
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd10;
        @(negedge clk);
        frame_stb = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        frame(0); frame(0); frame(0);
        chk("R7 discarded frame not counted", sf_active, 0);
        frame(0);
        chk("R7 full window of zeros", sf_active, 0);
    endtask

    task automatic t_zero_limit();
        wr_reg(2'd1, 8'd0);
        frame(0); frame(0); frame(0);
        chk("R3 limit 0 waits for full window", sf_active, 0);
        frame(0);
        chk("R3 limit 0 arms when full", sf_active, 1);
    endtask

    initial begin
        t_reset_defaults();
        t_arm_slide();
        t_release();
        t_flush_hold();
        t_coincident();
        t_zero_limit();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule